// File: doc/BRIEF.md
# Two-Share Masked AND-XOR Gadget

This block evaluates `a·b ^ c` on Boolean-masked data at first order. Every operand arrives as two shares whose XOR is the true value. No fresh random bits are used. One combinational stage forms four intermediate shares from the cross products. A register captures those four shares. An XOR stage after the register then folds them into a two-share result. That result is a uniform sharing of the output, so it can feed the next masked nonlinear stage without a refresh.

The gadget is bit-sliced over `WIDTH` independent lanes. It accepts a new operand set every cycle and returns it one cycle later. Its security rests on three conditions:
- The sharings of `a`, `b` and `c` must be independent of one another.
- The same variable must never be fed as both `a` and `b`.
- The compression pairing must stay as specified. Pairing the other way leaks `a`.

Top module: `share2_andxor`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` is 0 after that edge.
- R2: `out_valid` equals the `in_valid` value sampled one clock edge earlier. A stream of back-to-back valid inputs produces an output every cycle.
- R3: When `out_valid` is 1, `q_s0 ^ q_s1` equals `(a & b) ^ c` per lane. Here `a = a_s0 ^ a_s1` (and likewise for `b` and `c`) is taken from the inputs of the previous cycle.
- R4: Output share 0 equals `(a_s0&b_s0 ^ c_s0) ^ (a_s0&b_s1)`. It is formed from the first and second intermediate shares, and only index-0 shares of `a` and `c` reach it.
- R5: Output share 1 equals `(a_s1&b_s0 ^ c_s1) ^ (a_s1&b_s1)`. It is formed from the third and fourth intermediate shares.
- R6: Uniformity. Take any unshared `(a,b,c)` and all eight input sharings of it. Within each lane, the combination index has bit0=`a_s0`, bit1=`a_s1`, bit2=`b_s0`, bit3=`b_s1`, bit4=`c_s0` and bit5=`c_s1`. Across those eight sharings, `q_s0` is 0 exactly as often as it is 1.
- R7: A cycle with `in_valid` low leaves `q_s0` and `q_s1` unchanged, whatever the share inputs carry.
- R8: Lanes are independent. Lane k of the outputs depends only on lane k of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set present this cycle |
| a_s0 | input | WIDTH | Share 0 of a |
| a_s1 | input | WIDTH | Share 1 of a |
| b_s0 | input | WIDTH | Share 0 of b |
| b_s1 | input | WIDTH | Share 1 of b |
| c_s0 | input | WIDTH | Share 0 of c |
| c_s1 | input | WIDTH | Share 1 of c |
| out_valid | output | 1 | Result shares valid |
| q_s0 | output | WIDTH | Share 0 of a·b^c |
| q_s1 | output | WIDTH | Share 1 of a·b^c |

## Verification
Every lane is driven through all 64 share combinations in a back-to-back stream. Each lane uses a different offset, so the lanes carry different data in the same cycle. Checking each output share against its own formula catches a swapped compression pairing, which the share XOR alone would not reveal.

Counting the value of share 0 per unshared input over all sharings tells a uniform sharing apart from a biased one. An idle window with changing share inputs shows whether the capture register honours `in_valid`.

// File: rtl/share2_andxor_pkg.sv
package share2_andxor_pkg;
  localparam int IN_SHARES  = 2;
  localparam int MID_SHARES = 4;

  // Cross-product stage for one lane; each element touches a single index of a and c.
  function automatic logic [MID_SHARES-1:0] cross_terms(
    input logic a0, input logic a1,
    input logic b0, input logic b1,
    input logic c0, input logic c1);
    logic [MID_SHARES-1:0] m;
    m[0] = (a0 & b0) ^ c0;
    m[1] = a0 & b1;
    m[2] = (a1 & b0) ^ c1;
    m[3] = a1 & b1;
    return m;
  endfunction
endpackage

// File: rtl/share2_andxor_expand.sv
module share2_andxor_expand
  import share2_andxor_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]            a_s0,
  input  logic [WIDTH-1:0]            a_s1,
  input  logic [WIDTH-1:0]            b_s0,
  input  logic [WIDTH-1:0]            b_s1,
  input  logic [WIDTH-1:0]            c_s0,
  input  logic [WIDTH-1:0]            c_s1,
  output logic [MID_SHARES*WIDTH-1:0] mid
);
  for (genvar k = 0; k < WIDTH; k++) begin : g_lane
    assign mid[k*MID_SHARES +: MID_SHARES] =
      cross_terms(a_s0[k], a_s1[k], b_s0[k], b_s1[k], c_s0[k], c_s1[k]);
  end
endmodule

// File: rtl/share2_andxor_hold.sv
module share2_andxor_hold #(
  parameter int BITS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [BITS-1:0] d,
  output logic [BITS-1:0] q,
  output logic            vld
);
  // Share data carries no reset: only the qualifier does.
  always_ff @(posedge clk) begin
    if (en) q <= d;
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= 1'b0;
    else     vld <= en;
  end
endmodule

// File: rtl/share2_andxor_fold.sv
module share2_andxor_fold
  import share2_andxor_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [MID_SHARES*WIDTH-1:0] mid,
  output logic [WIDTH-1:0]            q_s0,
  output logic [WIDTH-1:0]            q_s1
);
  localparam int PAIR = MID_SHARES / IN_SHARES;

  // Pairs (0,1) and (2,3); pairing (1,3) would collapse to a*b_s1 and leak a.
  for (genvar k = 0; k < WIDTH; k++) begin : g_lane
    logic [MID_SHARES-1:0] m;
    assign m       = mid[k*MID_SHARES +: MID_SHARES];
    assign q_s0[k] = ^m[PAIR-1:0];
    assign q_s1[k] = ^m[MID_SHARES-1:PAIR];
  end
endmodule

// File: rtl/share2_andxor.sv
module share2_andxor
  import share2_andxor_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] a_s0,
  input  logic [WIDTH-1:0] a_s1,
  input  logic [WIDTH-1:0] b_s0,
  input  logic [WIDTH-1:0] b_s1,
  input  logic [WIDTH-1:0] c_s0,
  input  logic [WIDTH-1:0] c_s1,
  output logic             out_valid,
  output logic [WIDTH-1:0] q_s0,
  output logic [WIDTH-1:0] q_s1
);
  localparam int MID_BITS = MID_SHARES * WIDTH;

  logic [MID_BITS-1:0] mid_comb;
  logic [MID_BITS-1:0] mid_reg;

  share2_andxor_expand #(.WIDTH(WIDTH)) u_expand (
    .a_s0(a_s0), .a_s1(a_s1), .b_s0(b_s0), .b_s1(b_s1),
    .c_s0(c_s0), .c_s1(c_s1), .mid(mid_comb)
  );

  // Non-uniform four-share value must settle in flops before any folding.
  share2_andxor_hold #(.BITS(MID_BITS)) u_hold (
    .clk(clk), .rst(rst), .en(in_valid),
    .d(mid_comb), .q(mid_reg), .vld(out_valid)
  );

  share2_andxor_fold #(.WIDTH(WIDTH)) u_fold (
    .mid(mid_reg), .q_s0(q_s0), .q_s1(q_s1)
  );
endmodule

// File: rtl/share2_andxor_chk.sv
module share2_andxor_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [WIDTH-1:0] a_s0,
  input logic [WIDTH-1:0] a_s1,
  input logic [WIDTH-1:0] b_s0,
  input logic [WIDTH-1:0] b_s1,
  input logic [WIDTH-1:0] c_s0,
  input logic [WIDTH-1:0] c_s1,
  input logic             out_valid,
  input logic [WIDTH-1:0] q_s0,
  input logic [WIDTH-1:0] q_s1
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3
  unmasked_value_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((q_s0 ^ q_s1) ==
      $past(((a_s0 ^ a_s1) & (b_s0 ^ b_s1)) ^ (c_s0 ^ c_s1))));

  // R4
  share0_index_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (q_s0 == $past((a_s0 & (b_s0 ^ b_s1)) ^ c_s0)));

  // R5
  share1_index_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (q_s1 == $past((a_s1 & (b_s0 ^ b_s1)) ^ c_s1)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(q_s0) && $stable(q_s1)));
endmodule

bind share2_andxor share2_andxor_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .a_s0(a_s0), .a_s1(a_s1), .b_s0(b_s0), .b_s1(b_s1),
  .c_s0(c_s0), .c_s1(c_s1),
  .out_valid(out_valid), .q_s0(q_s0), .q_s1(q_s1)
);

// File: tb/share2_andxor_test.sv
module share2_andxor_test;
  localparam int W = 4;

  typedef struct packed {
    logic [W-1:0]   e0;
    logic [W-1:0]   e1;
    logic [3*W-1:0] u;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] a_s0 = '0, a_s1 = '0, b_s0 = '0, b_s1 = '0, c_s0 = '0, c_s1 = '0;
  logic out_valid;
  logic [W-1:0] q_s0, q_s1;

  int checks = 0;
  int fails = 0;
  int ucnt [8][2];
  item_t expq[$];
  item_t last_exp;
  bit done = 1'b0;

  always #2 clk = ~clk;

  share2_andxor #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_s0(a_s0), .a_s1(a_s1), .b_s0(b_s0), .b_s1(b_s1),
    .c_s0(c_s0), .c_s1(c_s1),
    .out_valid(out_valid), .q_s0(q_s0), .q_s1(q_s1)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one operand set: lane k gets combination index (i + 21*k) mod 64.
  task automatic drive(input int i);
    item_t it;
    @(posedge clk); #1;
    in_valid = 1'b1;
    for (int k = 0; k < W; k++) begin
      logic [5:0] ix;
      logic a, b, c;
      ix = 6'((i + 21 * k) % 64);
      a_s0[k] = ix[0]; a_s1[k] = ix[1];
      b_s0[k] = ix[2]; b_s1[k] = ix[3];
      c_s0[k] = ix[4]; c_s1[k] = ix[5];
      a = ix[0] ^ ix[1]; b = ix[2] ^ ix[3]; c = ix[4] ^ ix[5];
      it.e0[k] = (ix[0] & ix[2]) ^ ix[4] ^ (ix[0] & ix[3]);  // R4
      it.e1[k] = (ix[1] & ix[2]) ^ ix[5] ^ (ix[1] & ix[3]);  // R5
      it.u[3*k +: 3] = {a, b, c};
    end
    expq.push_back(it);
    last_exp = it;
  endtask

  // Monitor: compare at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (expq.size() == 0) begin
          check(1'b0, "R2 unexpected out_valid", 32'(out_valid), 32'd0);
        end else begin
          item_t e;
          e = expq.pop_front();
          check(q_s0 == e.e0, "R4 share0", 32'(q_s0), 32'(e.e0));
          check(q_s1 == e.e1, "R5 share1", 32'(q_s1), 32'(e.e1));
          for (int k = 0; k < W; k++) begin
            logic [2:0] u;
            logic d;
            u = e.u[3*k +: 3];
            d = (u[2] & u[1]) ^ u[0];
            // R3 R8 per-lane unmasked value
            check((q_s0[k] ^ q_s1[k]) == d, "R3/R8 lane value", 32'(q_s0[k] ^ q_s1[k]), 32'(d));
            ucnt[u][q_s0[k]]++;
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int u = 0; u < 8; u++) begin
      ucnt[u][0] = 0;
      ucnt[u][1] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 reset out_valid", 32'(out_valid), 32'd0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 idle after reset", 32'(out_valid), 32'd0);

    // R2: back-to-back stream of all 64 combinations on every lane.
    for (int i = 0; i < 64; i++) drive(i);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b1, "R2 last output timing", 32'(out_valid), 32'd1);

    // R7: idle cycles with changing shares must not move the outputs.
    for (int j = 0; j < 3; j++) begin
      @(posedge clk); #1;
      a_s0 = ~a_s0; b_s1 = b_s1 ^ 4'h5; c_s0 = ~c_s0; c_s1 = 4'(j + 3);
      @(negedge clk);
      check(out_valid == 1'b0, "R2 idle out_valid", 32'(out_valid), 32'd0);
      check(q_s0 == last_exp.e0, "R7 hold share0", 32'(q_s0), 32'(last_exp.e0));
      check(q_s1 == last_exp.e1, "R7 hold share1", 32'(q_s1), 32'(last_exp.e1));
    end
    check(expq.size() == 0, "R2 all results returned", 32'(expq.size()), 32'd0);

    // R6: eight sharings per unshared value per lane, W lanes.
    for (int u = 0; u < 8; u++) begin
      check(ucnt[u][0] == 4 * W && ucnt[u][1] == 4 * W, "R6 uniform share0",
            32'(ucnt[u][0]), 32'(4 * W));
    end

    // R2 gapped traffic: single valid between idles.
    drive(5);
    @(posedge clk); #1;
    in_valid = 1'b0;
    drive(40);
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R2 gapped results returned", 32'(expq.size()), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule